// File: doc/BRIEF.md
# SCL Low-Hold Timeout Detector

This block guards a master-mode serial bus transfer against a target device that stretches the clock for too long. It watches the clock line of the bus. While the controller is in master mode and a transfer is in progress, it counts serial-clock ticks for as long as the line stays low. Once the line has been held low for more ticks than the programmed limit allows, it issues a timeout event to the interrupt logic.

The limit is an 8-bit register. A single-cycle write strobe loads it, and its value can be read back. The tick input is a one-cycle enable at the serial-clock rate, so the count runs at bus speed while all logic sits in one system clock domain. The clock line is asynchronous to that domain and is resynchronized before any use. The event is a one-cycle pulse. It is also presented on a flag vector, at the bit position the interrupt bank decodes as transfer timeout.

Top module: `scl_stall_watchdog`

## Requirements
- R1: After reset, `limit_q` reads 0x1F, and `timeout_evt` and every bit of `irq_flags` are 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the limit register. The new value is visible on `limit_q` from the next cycle.
- R3: The block is armed while `master_en` and `xfer_busy` are high and the synchronized clock line is low. The tick that brings the count of armed `tick_en` cycles to limit + 1 produces `timeout_evt` in the cycle after that tick. Cycles with `tick_en` low are not counted.
- R4: The count returns to zero whenever the synchronized line is high, `xfer_busy` is low or `master_en` is low. With `master_en` low, no event is raised however many ticks arrive.
- R5: `timeout_evt` is high for exactly one cycle per low-hold episode. After it fires, no further event occurs until the synchronized line has been seen high, even if the transfer stops and restarts in the meantime.
- R6: An episode is judged against the limit value held when the block became armed. A write during the episode, including one in the same cycle as the final tick, takes effect from the next episode.
- R7: The clock line passes through a two-stage synchronizer. A rise of `scl_in` stops the count only two clock edges later, so ticks at those two edges still count.
- R8: `irq_flags` is 8 bits wide. Bit 3 carries the timeout pulse and the other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_wdata | input | 8 | Limit write value |
| limit_q | output | 8 | Current limit register value |
| scl_in | input | 1 | Raw bus clock line level |
| tick_en | input | 1 | One-cycle serial-clock tick enable |
| master_en | input | 1 | Controller is in master mode |
| xfer_busy | input | 1 | A master transfer is in progress |
| timeout_evt | output | 1 | One-cycle timeout pulse |
| irq_flags | output | 8 | Event vector to the interrupt bank, timeout at bit 3 |

## Verification
Two functions can fall in the same cycle: a register write and the counting tick that fires the event. The bench provokes this by asserting `cfg_we` with a new limit at the same edge as the final tick of an episode. The event must still arrive on that tick, as set by the old limit, and the next episode must then use the new value. A second overlap is a rise of the line that coincides with live ticks. The expected event edge is computed from the two-edge synchronizer delay. Limits 0 to 9 are swept against tick periods 1 to 3, and the single pulse is checked against the tick arithmetic for each pair.

// File: rtl/scl_wd_pkg.sv
package scl_wd_pkg;
   localparam int unsigned LIMIT_W_DEF   = 8;
   localparam int unsigned LIMIT_RST_DEF = 8'h1F;
   localparam int unsigned FLAG_W_DEF    = 8;
   localparam int unsigned TO_FLAG_POS   = 3;
   localparam int unsigned SYNC_DEF      = 2;

   typedef enum logic [1:0] {
      WD_IDLE  = 2'd0,
      WD_COUNT = 2'd1,
      WD_FIRED = 2'd2
   } wd_phase_e;

   function automatic logic [FLAG_W_DEF-1:0] place_flag(input logic bit_v);
      logic [FLAG_W_DEF-1:0] v;
      v = '0;
      v[TO_FLAG_POS] = bit_v;
      return v;
   endfunction
endpackage

// File: rtl/scl_wd_sync.sv
module scl_wd_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          RST_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scl_wd_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_LVL;
      else        chain_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RST_LVL;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/scl_wd_limit_reg.sv
module scl_wd_limit_reg #(
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned RST_VAL = 8'h1F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] value_q
);
   if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
      $error("scl_wd_limit_reg width out of range");
   end
   if (RST_VAL >= (1 << WIDTH)) begin : g_bad_rst
      $error("scl_wd_limit_reg reset value does not fit");
   end

   localparam logic [WIDTH-1:0] RST_Q = WIDTH'(RST_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  value_q <= RST_Q;
      else if (we) value_q <= wdata;
   end

   p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (value_q == $past(wdata)));
endmodule

// File: rtl/scl_wd_lowcnt.sv
module scl_wd_lowcnt
   import scl_wd_pkg::*;
#(
   parameter int unsigned LIMIT_W = 8,
   parameter int unsigned RST_VAL = 8'h1F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_low,
   input  logic               scl_high,
   input  logic               active,
   input  logic               tick,
   input  logic [LIMIT_W-1:0] limit,
   output logic               evt_q
);
   localparam int unsigned CNT_W = LIMIT_W + 1;
   localparam logic [LIMIT_W-1:0] HELD_RST = LIMIT_W'(RST_VAL);

   logic               armed;
   logic [CNT_W-1:0]   cnt_q;
   logic [LIMIT_W-1:0] held_q;
   wd_phase_e          phase_q;
   logic               hit;

   assign armed = active && scl_low;
   assign hit   = armed && tick && (phase_q != WD_FIRED) &&
                  (cnt_q == {1'b0, held_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= HELD_RST;
      end else if (!armed) begin
         held_q <= limit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= WD_IDLE;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= hit;
         if (!armed) begin
            cnt_q <= '0;
            if (scl_high)               phase_q <= WD_IDLE;
            else if (phase_q == WD_COUNT) phase_q <= WD_IDLE;
         end else if (phase_q != WD_FIRED) begin
            if (tick) cnt_q <= cnt_q + 1'b1;
            phase_q <= hit ? WD_FIRED : WD_COUNT;
         end
      end
   end

   p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> (cnt_q == '0));
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |=> !evt_q);
   p_evt_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> $past(tick && active && scl_low));
   p_held_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(armed)) |-> $stable(held_q));
   p_no_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == WD_FIRED && !scl_high) |=> (phase_q == WD_FIRED || armed));
endmodule

// File: rtl/scl_stall_watchdog.sv
module scl_stall_watchdog
   import scl_wd_pkg::*;
#(
   parameter int unsigned LIMIT_W    = LIMIT_W_DEF,
   parameter int unsigned LIMIT_RST  = LIMIT_RST_DEF,
   parameter int unsigned SYNC_STG   = SYNC_DEF,
   parameter int unsigned FLAG_W     = FLAG_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [LIMIT_W-1:0] cfg_wdata,
   output logic [LIMIT_W-1:0] limit_q,
   input  logic               scl_in,
   input  logic               tick_en,
   input  logic               master_en,
   input  logic               xfer_busy,
   output logic               timeout_evt,
   output logic [FLAG_W-1:0]  irq_flags
);
   if (FLAG_W != FLAG_W_DEF) begin : g_bad_flags
      $error("scl_stall_watchdog flag vector width must match the package");
   end

   logic scl_s;
   logic evt;

   scl_wd_sync #(.STAGES(SYNC_STG), .RST_LVL(1'b1)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(scl_in),
      .q_sync (scl_s)
   );

   scl_wd_limit_reg #(.WIDTH(LIMIT_W), .RST_VAL(LIMIT_RST)) u_limit (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wdata  (cfg_wdata),
      .value_q(limit_q)
   );

   scl_wd_lowcnt #(.LIMIT_W(LIMIT_W), .RST_VAL(LIMIT_RST)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_low (!scl_s),
      .scl_high(scl_s),
      .active  (master_en && xfer_busy),
      .tick    (tick_en),
      .limit   (limit_q),
      .evt_q   (evt)
   );

   assign timeout_evt = evt;
   assign irq_flags   = place_flag(evt);

   p_master_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_evt |-> $past(master_en && xfer_busy));
   p_flag_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_flags) && (timeout_evt == (irq_flags != '0)));
endmodule

// File: tb/scl_stall_watchdog_tb.sv
module scl_stall_watchdog_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] limit_q;
   logic       scl = 1'b1;
   logic       tick = 1'b0;
   logic       master = 1'b1;
   logic       busy = 1'b0;
   logic       evt;
   logic [7:0] flags;

   int n_tests = 0;
   int n_fail  = 0;
   int evt_cnt = 0;

   always #2.5 clk = ~clk;

   scl_stall_watchdog u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata), .limit_q(limit_q),
      .scl_in(scl), .tick_en(tick), .master_en(master), .xfer_busy(busy),
      .timeout_evt(evt), .irq_flags(flags)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: drive tick at a negedge, sample after the posedge, back at negedge
   task automatic step(input logic t);
      tick = t;
      @(posedge clk); #1;
      if (evt) evt_cnt++;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic wr(input logic [7:0] v);
      we = 1'b1; wdata = v;
      @(posedge clk); #1;
      @(negedge clk);
      we = 1'b0;
   endtask

   // high for a while (clears fired state), then low and settled, busy still low
   task automatic prep_low();
      busy = 1'b0; scl = 1'b1;
      repeat (4) step(1'b0);
      scl = 1'b0;
      repeat (3) step(1'b0);
   endtask

   task automatic run_ep(input int lim, input int per, input int wr_at,
                         input logic [7:0] wr_val, input string req);
      int ticks = 0, hit = -1, pulses = 0, exp_at = -1;
      bit flag_bad = 0;
      prep_low();
      busy = 1'b1;
      for (int k = 0; k < (lim + 2) * per + 6; k++) begin
         tick = ((k % per) == per - 1);
         we = tick && (wr_at == ticks);
         wdata = wr_val;
         if (tick) begin
            ticks++;
            if (ticks == lim + 1) exp_at = k;
         end
         @(posedge clk); #1;
         if (evt) begin
            pulses++; hit = k;
            if (flags !== 8'h08) flag_bad = 1;
         end
         @(negedge clk);
         we = 1'b0; tick = 1'b0;
      end
      busy = 1'b0;
      check(pulses == 1 && hit == exp_at, req, hit, exp_at);
      check(!flag_bad, "R8 flag vector bit 3 only", flags, 8);
   endtask

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(limit_q == 8'h1F, "R1 reset limit", limit_q, 31);
      check(evt == 1'b0 && flags == 8'h00, "R1 reset outputs", flags, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R3 reset limit used directly
      run_ep(31, 1, -1, 8'h00, "R1 R3 reset limit episode");

      // R2 write and readback
      wr(8'hA5);
      check(limit_q == 8'hA5, "R2 limit readback", limit_q, 165);

      // R3 sweep of limits against tick periods
      for (int l = 0; l < 10; l++) begin
         for (int p = 1; p <= 3; p++) begin
            wr(8'(l));
            run_ep(l, p, -1, 8'h00, "R3 sweep");
         end
      end
      wr(8'hFF);
      run_ep(255, 1, -1, 8'h00, "R3 max limit");

      // R6 write in same cycle as the firing tick
      wr(8'd3);
      run_ep(3, 2, 3, 8'h00, "R6 write on firing tick");
      check(limit_q == 8'h00, "R6 concurrent write landed", limit_q, 0);
      run_ep(0, 1, -1, 8'h00, "R6 next episode new limit");

      // R6 write mid-episode
      wr(8'd5);
      run_ep(5, 1, 2, 8'd20, "R6 mid-episode write");
      run_ep(20, 1, -1, 8'h00, "R6 following episode");

      // R4 clear on SCL high mid-count
      wr(8'd4);
      prep_low(); busy = 1'b1; evt_cnt = 0;
      repeat (3) step(1'b1);
      scl = 1'b1; repeat (4) step(1'b0);
      scl = 1'b0; repeat (3) step(1'b0);
      repeat (4) step(1'b1);
      check(evt_cnt == 0, "R4 count cleared by SCL high", evt_cnt, 0);
      step(1'b1);
      check(evt_cnt == 1, "R4 fresh count fires", evt_cnt, 1);

      // R4 master off
      prep_low(); master = 1'b0; busy = 1'b1; evt_cnt = 0;
      repeat (40) step(1'b1);
      check(evt_cnt == 0, "R4 master off no event", evt_cnt, 0);
      master = 1'b1;

      // R4 busy drop clears count
      prep_low(); busy = 1'b1; evt_cnt = 0;
      repeat (3) step(1'b1);
      busy = 1'b0; repeat (2) step(1'b1);
      busy = 1'b1;
      repeat (4) step(1'b1);
      check(evt_cnt == 0, "R4 count cleared by busy low", evt_cnt, 0);
      step(1'b1);
      check(evt_cnt == 1, "R4 fires after restart", evt_cnt, 1);

      // R5 no rearm while low
      repeat (20) step(1'b1);
      busy = 1'b0; repeat (2) step(1'b0); busy = 1'b1;
      repeat (20) step(1'b1);
      check(evt_cnt == 1, "R5 no second event while low", evt_cnt, 1);
      prep_low(); busy = 1'b1;
      repeat (5) step(1'b1);
      check(evt_cnt == 2, "R5 rearm after SCL high", evt_cnt, 2);

      // R7 synchronizer delay: rise of scl_in still lets two ticks count
      wr(8'd3);
      prep_low(); busy = 1'b1; evt_cnt = 0;
      repeat (2) step(1'b1);
      scl = 1'b1;
      step(1'b1);
      check(evt_cnt == 0, "R7 third tick no event yet", evt_cnt, 0);
      step(1'b1);
      check(evt_cnt == 1, "R7 fourth tick counted through sync delay", evt_cnt, 1);
      repeat (10) step(1'b1);
      check(evt_cnt == 1, "R7 count stops after sync", evt_cnt, 1);
      busy = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule